// File: doc/BRIEF.md
# I2C Master Bridge Host Register Block

This block is the host-facing register file in front of an I2C master transaction engine. A host reaches it through a byte-wide port: one byte read or one byte write per cycle. Wider host accesses are split into consecutive byte accesses. The block stores the engine's configuration: SCL timing, the number of address bytes, the number of data bytes, and a block-read request. It also holds a shared byte buffer. Outgoing address and payload bytes are staged in the buffer, and the engine returns received bytes into it.

The host programs the counts and fills the buffer first. It then writes the command byte, which carries the 7-bit target address and the direction. That write starts the transaction. The block tracks busy and done. When the engine finishes, status shows the bridge idle again and whether the target refused with a NACK. For a block read that completes with an ACK, the data-count register is loaded with the real number of bytes received. Writing the control register with its low bit cleared aborts everything and returns the bridge to idle.

Top module: `i2cb_host_regs`

## Requirements
- R1: After reset the registers read as follows: status 0x01, control 0x01, half-cycle 100, hold 25, command 0x00. Every host read returns its byte on `hst_rdata` in the cycle after `rd_en`.
- R2: Capability (offset 0x0) reads bit 7 = 1 when block reads are supported and bits [6:5] = 01 when the 72-byte buffer is built (00 for 36 bytes). All other capability bits read 0.
- R3: The half-cycle (0x4) and hold (0x5) registers can be read and written. Their values drive `eng_half` and `eng_hold` unchanged, and those outputs change only on a host write to their offset.
- R4: A host write to the command offset (0x6) while idle gives a one-cycle `eng_start` in the following cycle. It also sets `eng_target` = data[7:1] and `eng_read` = data[0] (1 = read). From that cycle, status bit 0 reads 0.
- R5: A command write while a transaction is in progress is ignored. No start pulse follows, `eng_target` and `eng_read` keep their values, and status bit 0 stays 0.
- R6: An `eng_done` pulse during a transaction sets status bit 0 to 1 and latches `eng_nack` into status bit 4. Bit 4 is cleared at the next start. An `eng_done` while idle has no effect on status.
- R7: Address count (0x8) bits [2:0] drive `eng_addr_bytes`. Bit 7 drives `eng_block` only when block support is built. Data count (0x7) drives `eng_data_bytes`.
- R8: When a transaction started with the block flag set completes without NACK, the data-count register is loaded with `eng_rx_len`. Any other completion leaves data count unchanged.
- R9: Buffer byte i sits at host offset 0xA+i for i from 0 to size-1. Bytes written by the host are visible at the engine buffer port, which has a one-cycle read latency. Bytes the engine writes are visible to the host.
- R10: A host write to control (0x1) with bit 0 = 0 forces the bridge idle (status 0x01, NACK cleared) and gives a one-cycle `eng_abort` in the following cycle.
- R11: Offsets that hold no register read 0x00. Host writes to status and capability leave their read values unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| hst_addr | input | 8 | Host byte offset |
| hst_wr_en | input | 1 | Host byte write strobe |
| hst_wdata | input | 8 | Host write byte |
| hst_rd_en | input | 1 | Host byte read strobe |
| hst_rdata | output | 8 | Host read byte, valid the cycle after hst_rd_en |
| eng_start | output | 1 | One-cycle transaction launch |
| eng_abort | output | 1 | One-cycle soft-reset request to the engine |
| eng_target | output | 7 | 7-bit target address |
| eng_read | output | 1 | Direction, 1 = read |
| eng_addr_bytes | output | 3 | Address/register byte count |
| eng_data_bytes | output | 8 | Data byte count |
| eng_block | output | 1 | Block-read request |
| eng_half | output | 8 | SCL half-cycle setting |
| eng_hold | output | 8 | Data hold setting |
| eng_buf_en | input | 1 | Engine buffer access enable |
| eng_buf_we | input | 1 | Engine buffer write |
| eng_buf_idx | input | BUF_AW | Engine buffer byte index |
| eng_buf_wdata | input | 8 | Engine buffer write byte |
| eng_buf_rdata | output | 8 | Engine buffer read byte, one-cycle latency |
| eng_done | input | 1 | Transaction finished pulse |
| eng_nack | input | 1 | Target refused, sampled with eng_done |
| eng_rx_len | input | 8 | Bytes received in a block read, sampled with eng_done |

## Verification
The bench first writes the command register while busy. A design that re-launched here would emit a second start pulse or overwrite the target address. The bench then completes a transaction with NACK after one with ACK. A design that let NACK stick would show bit 4 on the next clean run, and one that ignored NACK would report a refused transfer as a success. The block-read count load is checked against a plain read that also reports a length: a design that always loaded the count would corrupt data count on the plain read. A soft reset is issued mid-transfer and a stray done arrives while idle. A bridge that stayed busy after the reset, or that honoured the stray done, would show the wrong status byte.

// File: rtl/i2cb_pkg.sv
package i2cb_pkg;
  localparam logic [7:0] OFS_CAP  = 8'h00;
  localparam logic [7:0] OFS_CTRL = 8'h01;
  localparam logic [7:0] OFS_HALF = 8'h04;
  localparam logic [7:0] OFS_HOLD = 8'h05;
  localparam logic [7:0] OFS_CMD  = 8'h06;
  localparam logic [7:0] OFS_DCNT = 8'h07;
  localparam logic [7:0] OFS_ACNT = 8'h08;
  localparam logic [7:0] OFS_STAT = 8'h09;
  localparam logic [7:0] OFS_BUF  = 8'h0A;

  localparam int ST_IDLE_BIT  = 0;
  localparam int ST_NACK_BIT  = 4;
  localparam int CTRL_RUN_BIT = 0;
  localparam int ACNT_BLK_BIT = 7;

  typedef enum logic {PH_IDLE, PH_RUN} phase_e;

  function automatic logic [7:0] status_byte(input logic busy, input logic nack);
    logic [7:0] s;
    s = 8'h00;
    s[ST_IDLE_BIT] = ~busy;
    s[ST_NACK_BIT] = nack;
    return s;
  endfunction
endpackage

// File: rtl/i2cb_dpram.sv
module i2cb_dpram #(
  parameter int DEPTH = 72,
  parameter int AW    = 7
) (
  input  logic          clk,
  input  logic          a_en,
  input  logic          a_we,
  input  logic [AW-1:0] a_idx,
  input  logic [7:0]    a_wdata,
  output logic [7:0]    a_rdata,
  input  logic          b_en,
  input  logic          b_we,
  input  logic [AW-1:0] b_idx,
  input  logic [7:0]    b_wdata,
  output logic [7:0]    b_rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (a_en && a_we && (int'(a_idx) < DEPTH)) mem[a_idx] <= a_wdata;
    if (b_en && b_we && (int'(b_idx) < DEPTH)) mem[b_idx] <= b_wdata;
    if (a_en && !a_we) a_rdata <= (int'(a_idx) < DEPTH) ? mem[a_idx] : 8'h00;
    if (b_en && !b_we) b_rdata <= (int'(b_idx) < DEPTH) ? mem[b_idx] : 8'h00;
  end
endmodule

// File: rtl/i2cb_seq.sv
module i2cb_seq
  import i2cb_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic launch,
  input  logic soft_rst,
  input  logic blk_req,
  input  logic done,
  input  logic nack,
  output logic busy,
  output logic nack_q,
  output logic start_q,
  output logic abort_q,
  output logic cnt_load
);
  phase_e ph;
  logic   blk_q;

  assign busy     = (ph == PH_RUN);
  assign cnt_load = busy && done && !nack && blk_q && !soft_rst;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph      <= PH_IDLE;
      nack_q  <= 1'b0;
      start_q <= 1'b0;
      abort_q <= 1'b0;
      blk_q   <= 1'b0;
    end else begin
      start_q <= 1'b0;
      abort_q <= 1'b0;
      if (soft_rst) begin
        ph      <= PH_IDLE;
        nack_q  <= 1'b0;
        abort_q <= 1'b1;
      end else begin
        case (ph)
          PH_IDLE: if (launch) begin
            ph      <= PH_RUN;
            start_q <= 1'b1;
            nack_q  <= 1'b0;
            blk_q   <= blk_req;
          end
          PH_RUN: if (done) begin
            ph     <= PH_IDLE;
            nack_q <= nack;
          end
          default: ph <= PH_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2cb_regs.sv
module i2cb_regs
  import i2cb_pkg::*;
#(
  parameter int BUF_BYTES   = 72,
  parameter int BUF_AW      = 7,
  parameter int EXT_BUF     = 1,
  parameter int BLK_SUPPORT = 1,
  parameter int HALF_RST    = 100,
  parameter int HOLD_RST    = 25
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [7:0]        hst_addr,
  input  logic              hst_wr_en,
  input  logic [7:0]        hst_wdata,
  input  logic              hst_rd_en,
  output logic [7:0]        hst_rdata,
  input  logic              busy,
  input  logic              nack,
  input  logic              cnt_load,
  input  logic [7:0]        rx_len,
  output logic              launch,
  output logic              soft_rst,
  output logic [7:0]        cmd_q,
  output logic [7:0]        acnt_q,
  output logic [7:0]        dcnt_q,
  output logic [7:0]        half_q,
  output logic [7:0]        hold_q,
  output logic              buf_en,
  output logic              buf_we,
  output logic [BUF_AW-1:0] buf_idx,
  output logic [7:0]        buf_wdata,
  input  logic [7:0]        buf_rdata
);
  localparam logic [8:0] BUF_END = 9'(OFS_BUF) + 9'(BUF_BYTES);
  localparam logic [7:0] CAP_VAL = {(BLK_SUPPORT != 0), ((EXT_BUF != 0) ? 2'b01 : 2'b00), 5'b00000};

  logic [7:0] ctrl_q;
  logic [7:0] rd_reg_q;
  logic       rd_buf_q;
  logic       hit_buf;
  logic [7:0] reg_view;

  assign hit_buf   = (hst_addr >= OFS_BUF) && ({1'b0, hst_addr} < BUF_END);
  assign buf_en    = hit_buf && (hst_wr_en || hst_rd_en);
  assign buf_we    = hit_buf && hst_wr_en;
  assign buf_idx   = BUF_AW'(hst_addr - OFS_BUF);
  assign buf_wdata = hst_wdata;

  assign launch   = hst_wr_en && (hst_addr == OFS_CMD) && !busy;
  assign soft_rst = hst_wr_en && (hst_addr == OFS_CTRL) && !hst_wdata[CTRL_RUN_BIT];

  always_comb begin
    case (hst_addr)
      OFS_CAP:  reg_view = CAP_VAL;
      OFS_CTRL: reg_view = ctrl_q;
      OFS_HALF: reg_view = half_q;
      OFS_HOLD: reg_view = hold_q;
      OFS_CMD:  reg_view = cmd_q;
      OFS_DCNT: reg_view = dcnt_q;
      OFS_ACNT: reg_view = acnt_q;
      OFS_STAT: reg_view = status_byte(busy, nack);
      default:  reg_view = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= 8'h01;
      half_q   <= 8'(HALF_RST);
      hold_q   <= 8'(HOLD_RST);
      cmd_q    <= 8'h00;
      dcnt_q   <= 8'h00;
      acnt_q   <= 8'h00;
      rd_reg_q <= 8'h00;
      rd_buf_q <= 1'b0;
    end else begin
      if (hst_wr_en) begin
        case (hst_addr)
          OFS_CTRL: ctrl_q <= hst_wdata;
          OFS_HALF: half_q <= hst_wdata;
          OFS_HOLD: hold_q <= hst_wdata;
          OFS_ACNT: acnt_q <= hst_wdata;
          default: ;
        endcase
      end
      if (launch) cmd_q <= hst_wdata;
      if (cnt_load) dcnt_q <= rx_len;
      else if (hst_wr_en && hst_addr == OFS_DCNT) dcnt_q <= hst_wdata;
      if (hst_rd_en) begin
        rd_reg_q <= reg_view;
        rd_buf_q <= hit_buf;
      end
    end
  end

  assign hst_rdata = rd_buf_q ? buf_rdata : rd_reg_q;
endmodule

// File: rtl/i2cb_host_regs.sv
module i2cb_host_regs
  import i2cb_pkg::*;
#(
  parameter int EXT_BUF        = 1,
  parameter int BLK_SUPPORT    = 1,
  parameter int BASE_BUF_BYTES = 36,
  parameter int SYS_CLK_KHZ    = 20000,
  parameter int SCL_KHZ        = 100,
  localparam int BUF_BYTES     = (EXT_BUF != 0) ? 2 * BASE_BUF_BYTES : BASE_BUF_BYTES,
  localparam int BUF_AW        = $clog2(BUF_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [7:0]        hst_addr,
  input  logic              hst_wr_en,
  input  logic [7:0]        hst_wdata,
  input  logic              hst_rd_en,
  output logic [7:0]        hst_rdata,
  output logic              eng_start,
  output logic              eng_abort,
  output logic [6:0]        eng_target,
  output logic              eng_read,
  output logic [2:0]        eng_addr_bytes,
  output logic [7:0]        eng_data_bytes,
  output logic              eng_block,
  output logic [7:0]        eng_half,
  output logic [7:0]        eng_hold,
  input  logic              eng_buf_en,
  input  logic              eng_buf_we,
  input  logic [BUF_AW-1:0] eng_buf_idx,
  input  logic [7:0]        eng_buf_wdata,
  output logic [7:0]        eng_buf_rdata,
  input  logic              eng_done,
  input  logic              eng_nack,
  input  logic [7:0]        eng_rx_len
);
  localparam int HALF_RST = SYS_CLK_KHZ / (2 * SCL_KHZ);
  localparam int HOLD_RST = HALF_RST / 4;

  logic              seq_busy, seq_nack, cnt_load, launch, soft_rst;
  logic [7:0]        cmd_q, acnt_q, dcnt_q;
  logic              h_buf_en, h_buf_we;
  logic [BUF_AW-1:0] h_buf_idx;
  logic [7:0]        h_buf_wdata, h_buf_rdata;

  i2cb_regs #(
    .BUF_BYTES(BUF_BYTES), .BUF_AW(BUF_AW), .EXT_BUF(EXT_BUF),
    .BLK_SUPPORT(BLK_SUPPORT), .HALF_RST(HALF_RST), .HOLD_RST(HOLD_RST)
  ) u_regs (
    .clk(clk), .rst(rst),
    .hst_addr(hst_addr), .hst_wr_en(hst_wr_en), .hst_wdata(hst_wdata),
    .hst_rd_en(hst_rd_en), .hst_rdata(hst_rdata),
    .busy(seq_busy), .nack(seq_nack), .cnt_load(cnt_load), .rx_len(eng_rx_len),
    .launch(launch), .soft_rst(soft_rst),
    .cmd_q(cmd_q), .acnt_q(acnt_q), .dcnt_q(dcnt_q),
    .half_q(eng_half), .hold_q(eng_hold),
    .buf_en(h_buf_en), .buf_we(h_buf_we), .buf_idx(h_buf_idx),
    .buf_wdata(h_buf_wdata), .buf_rdata(h_buf_rdata)
  );

  i2cb_seq u_seq (
    .clk(clk), .rst(rst),
    .launch(launch), .soft_rst(soft_rst), .blk_req(eng_block),
    .done(eng_done), .nack(eng_nack),
    .busy(seq_busy), .nack_q(seq_nack),
    .start_q(eng_start), .abort_q(eng_abort), .cnt_load(cnt_load)
  );

  i2cb_dpram #(.DEPTH(BUF_BYTES), .AW(BUF_AW)) u_buf (
    .clk(clk),
    .a_en(h_buf_en), .a_we(h_buf_we), .a_idx(h_buf_idx),
    .a_wdata(h_buf_wdata), .a_rdata(h_buf_rdata),
    .b_en(eng_buf_en), .b_we(eng_buf_we), .b_idx(eng_buf_idx),
    .b_wdata(eng_buf_wdata), .b_rdata(eng_buf_rdata)
  );

  assign eng_target     = cmd_q[7:1];
  assign eng_read       = cmd_q[0];
  assign eng_addr_bytes = acnt_q[2:0];
  assign eng_data_bytes = dcnt_q;
  assign eng_block      = acnt_q[ACNT_BLK_BIT] & (BLK_SUPPORT != 0);
endmodule

// File: rtl/i2cb_host_regs_chk.sv
module i2cb_host_regs_chk
  import i2cb_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic [7:0] hst_addr,
  input logic       hst_wr_en,
  input logic [7:0] hst_wdata,
  input logic       eng_start,
  input logic       eng_abort,
  input logic       eng_done,
  input logic [6:0] eng_target,
  input logic [7:0] eng_half,
  input logic [7:0] eng_hold,
  input logic       busy
);
  logic cmd_wr, ctrl_clr, tim_wr;
  assign cmd_wr   = hst_wr_en && (hst_addr == OFS_CMD);
  assign ctrl_clr = hst_wr_en && (hst_addr == OFS_CTRL) && !hst_wdata[CTRL_RUN_BIT];
  assign tim_wr   = hst_wr_en && ((hst_addr == OFS_HALF) || (hst_addr == OFS_HOLD));

  AST_START_FROM_CMD: assert property (@(posedge clk) disable iff (rst)
    eng_start |-> $past(cmd_wr)); // R4
  AST_START_PULSE: assert property (@(posedge clk) disable iff (rst)
    eng_start |=> !eng_start); // R4
  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (rst)
    (busy && cmd_wr) |=> (!eng_start && $stable(eng_target))); // R5
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    (busy && eng_done && !ctrl_clr) |=> !busy); // R6
  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (rst)
    eng_abort |-> !busy); // R10
  AST_TIMING_HOLD: assert property (@(posedge clk) disable iff (rst)
    !tim_wr |=> ($stable(eng_half) && $stable(eng_hold))); // R3
endmodule

bind i2cb_host_regs i2cb_host_regs_chk u_chk (
  .clk(clk), .rst(rst), .hst_addr(hst_addr), .hst_wr_en(hst_wr_en),
  .hst_wdata(hst_wdata), .eng_start(eng_start), .eng_abort(eng_abort),
  .eng_done(eng_done), .eng_target(eng_target), .eng_half(eng_half),
  .eng_hold(eng_hold), .busy(seq_busy)
);

// File: tb/tb_i2cb_host_regs.sv
module tb_i2cb_host_regs;
  localparam int AW = 7;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [7:0]    hst_addr = '0, hst_wdata = '0;
  logic          hst_wr_en = 1'b0, hst_rd_en = 1'b0;
  logic [7:0]    hst_rdata;
  logic          eng_start, eng_abort, eng_read, eng_block;
  logic [6:0]    eng_target;
  logic [2:0]    eng_addr_bytes;
  logic [7:0]    eng_data_bytes, eng_half, eng_hold, eng_buf_rdata;
  logic          eng_buf_en = 1'b0, eng_buf_we = 1'b0;
  logic [AW-1:0] eng_buf_idx = '0;
  logic [7:0]    eng_buf_wdata = '0;
  logic          eng_done = 1'b0, eng_nack = 1'b0;
  logic [7:0]    eng_rx_len = '0;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  i2cb_host_regs dut (
    .clk(clk), .rst(rst), .hst_addr(hst_addr), .hst_wr_en(hst_wr_en),
    .hst_wdata(hst_wdata), .hst_rd_en(hst_rd_en), .hst_rdata(hst_rdata),
    .eng_start(eng_start), .eng_abort(eng_abort), .eng_target(eng_target),
    .eng_read(eng_read), .eng_addr_bytes(eng_addr_bytes),
    .eng_data_bytes(eng_data_bytes), .eng_block(eng_block),
    .eng_half(eng_half), .eng_hold(eng_hold),
    .eng_buf_en(eng_buf_en), .eng_buf_we(eng_buf_we), .eng_buf_idx(eng_buf_idx),
    .eng_buf_wdata(eng_buf_wdata), .eng_buf_rdata(eng_buf_rdata),
    .eng_done(eng_done), .eng_nack(eng_nack), .eng_rx_len(eng_rx_len)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic hwr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    hst_addr = a; hst_wdata = d; hst_wr_en = 1'b1;
    @(negedge clk);
    hst_wr_en = 1'b0;
  endtask

  task automatic hrd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    hst_addr = a; hst_rd_en = 1'b1;
    @(negedge clk);
    hst_rd_en = 1'b0;
    d = hst_rdata;
  endtask

  task automatic ecomplete(input logic nk, input logic [7:0] len);
    @(negedge clk);
    eng_done = 1'b1; eng_nack = nk; eng_rx_len = len;
    @(negedge clk);
    eng_done = 1'b0; eng_nack = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    hrd(8'h09, v); check("R1", "status", v, 8'h01);
    hrd(8'h01, v); check("R1", "control", v, 8'h01);
    hrd(8'h04, v); check("R1", "half", v, 100);
    hrd(8'h05, v); check("R1", "hold", v, 25);
    hrd(8'h06, v); check("R1", "command", v, 8'h00);
    hrd(8'h00, v); check("R2", "capability", v, 8'hA0);
  endtask

  task automatic t_timing;
    logic [7:0] v;
    hwr(8'h04, 8'h37);
    hwr(8'h05, 8'h09);
    hrd(8'h04, v); check("R3", "half readback", v, 8'h37);
    hrd(8'h05, v); check("R3", "hold readback", v, 8'h09);
    check("R3", "eng_half", eng_half, 8'h37);
    check("R3", "eng_hold", eng_hold, 8'h09);
  endtask

  task automatic t_unmapped;
    logic [7:0] v;
    hrd(8'h02, v); check("R11", "hole 0x02", v, 8'h00);
    hrd(8'hF0, v); check("R11", "hole 0xF0", v, 8'h00);
    hwr(8'h09, 8'hFF);
    hrd(8'h09, v); check("R11", "status after write", v, 8'h01);
    hwr(8'h00, 8'h13);
    hrd(8'h00, v); check("R11", "cap after write", v, 8'hA0);
  endtask

  task automatic t_buffer;
    logic [7:0] v;
    for (int i = 0; i < 4; i++) hwr(8'h0A + 8'(i), 8'h10 + 8'(i));
    for (int i = 0; i < 4; i++) begin
      hrd(8'h0A + 8'(i), v); check("R9", "host buf readback", v, 8'h10 + i);
    end
    hwr(8'h51, 8'hE7);
    hrd(8'h51, v); check("R9", "last buf byte", v, 8'hE7);
    @(negedge clk);
    eng_buf_en = 1'b1; eng_buf_we = 1'b0; eng_buf_idx = 7'd2;
    @(negedge clk);
    eng_buf_en = 1'b0;
    check("R9", "engine sees host byte", eng_buf_rdata, 8'h12);
    @(negedge clk);
    eng_buf_en = 1'b1; eng_buf_we = 1'b1; eng_buf_idx = 7'd5; eng_buf_wdata = 8'h5A;
    @(negedge clk);
    eng_buf_en = 1'b0; eng_buf_we = 1'b0;
    hrd(8'h0F, v); check("R9", "host sees engine byte", v, 8'h5A);
  endtask

  task automatic t_launch_block;
    logic [7:0] v;
    hwr(8'h08, 8'h82);
    hwr(8'h07, 8'h03);
    hwr(8'h06, 8'hA5);
    check("R4", "start pulse", eng_start, 1);
    check("R4", "target", eng_target, 7'h52);
    check("R4", "direction", eng_read, 1);
    check("R7", "addr bytes", eng_addr_bytes, 2);
    check("R7", "block flag", eng_block, 1);
    check("R7", "data bytes", eng_data_bytes, 3);
    @(negedge clk);
    check("R4", "start width", eng_start, 0);
    hrd(8'h09, v); check("R4", "status busy", v, 8'h00);
    hwr(8'h06, 8'h30);
    check("R5", "no restart", eng_start, 0);
    check("R5", "target kept", eng_target, 7'h52);
    hrd(8'h09, v); check("R5", "still busy", v, 8'h00);
    hrd(8'h06, v); check("R5", "command kept", v, 8'hA5);
    ecomplete(1'b0, 8'h05);
    hrd(8'h09, v); check("R6", "done ack", v, 8'h01);
    hrd(8'h07, v); check("R8", "block count loaded", v, 8'h05);
  endtask

  task automatic t_nack;
    logic [7:0] v;
    hwr(8'h08, 8'h00);
    hwr(8'h07, 8'h04);
    hwr(8'h06, 8'h20);
    check("R4", "write direction", eng_read, 0);
    ecomplete(1'b1, 8'h09);
    hrd(8'h09, v); check("R6", "nack status", v, 8'h11);
    hrd(8'h07, v); check("R8", "count kept", v, 8'h04);
    hwr(8'h06, 8'h21);
    hrd(8'h09, v); check("R6", "nack cleared at start", v, 8'h00);
    ecomplete(1'b0, 8'h09);
    hrd(8'h09, v); check("R6", "clean done", v, 8'h01);
    hrd(8'h07, v); check("R8", "plain read count kept", v, 8'h04);
  endtask

  task automatic t_soft_reset;
    logic [7:0] v;
    hwr(8'h06, 8'h44);
    hwr(8'h01, 8'h00);
    check("R10", "abort pulse", eng_abort, 1);
    @(negedge clk);
    check("R10", "abort width", eng_abort, 0);
    hrd(8'h09, v); check("R10", "idle after reset", v, 8'h01);
    ecomplete(1'b1, 8'h00);
    hrd(8'h09, v); check("R6", "stray done ignored", v, 8'h01);
    hwr(8'h01, 8'h01);
    hwr(8'h06, 8'h44);
    check("R10", "relaunch after reset", eng_start, 1);
    ecomplete(1'b0, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_timing();
    t_unmapped();
    t_buffer();
    t_launch_block();
    t_nack();
    t_soft_reset();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule